// File: doc/BRIEF.md
# Not-Recently-Used Way Selector

This block picks replacement victims for a set-associative cache that has many sets and several ways per set. Each block in a set has one status bit, called eligible. The bit is 1 when the block has not been used since the last refresh of its set. Every hit and every fill is reported on the access port as a set index and a way number. The reported way's bit is cleared. If that clear would leave the set with no eligible way, every other way in the set becomes eligible again and the accessed way stays ineligible.

On a miss the cache controller raises a victim request for a set. The block scans that set's status word from way 0 upward and returns the first eligible way one cycle later. Installing the new line in the victim way is itself reported as an access, so the fill follows the same update rule. Tag comparison and data storage are handled elsewhere in the cache.

Top module: `nru_replacer`

## Requirements
- R1: After a synchronous reset every way of every set is eligible, and `victim_vld` is low.
- R2: An access with `touch_vld` high clears the eligible bit of way `touch_way` in set `touch_set` at the next clock edge, so later lookups of that set skip that way.
- R3: When an access clears the last eligible bit of a set, every other way of that set becomes eligible and the accessed way stays ineligible.
- R4: The victim is the lowest-numbered eligible way of the requested set, with way 0 checked first.
- R5: A victim request in cycle t gives `victim_vld` high and the victim on `victim_way` in cycle t+1. `victim_vld` is low in any cycle whose previous cycle had no request.
- R6: When an access and a victim request target the same set in the same cycle, the victim is taken from the status word as it was before that access.
- R7: An access changes only the status word of its own set. Lookups of other sets return the same victims as before.
- R8: An access to a way that is already ineligible, while other ways of the set are still eligible, leaves the set's victim unchanged.
- R9: Every set always holds at least one eligible way, so every victim request returns a way.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| touch_vld | input | 1 | Access strobe for a hit or a fill |
| touch_set | input | SET_W (4) | Set index of the access |
| touch_way | input | WAY_W (3) | Way number of the access |
| victim_req | input | 1 | Victim lookup request, raised on a miss |
| victim_set | input | SET_W (4) | Set index of the lookup |
| victim_vld | output | 1 | Victim result valid, one cycle after the request |
| victim_way | output | WAY_W (3) | Selected victim way |

## Verification
The hardest case to reach from the ports is the refresh in R3. A set has to be driven through a sequence of accesses that leaves exactly one eligible way, and only then is that last way accessed. The bench does this with long access sequences, both in order and scattered across the ways, and checks the victim before and after the access that triggers the refresh. It also raises an access and a lookup to the same set in the same cycle, which shows whether the lookup reads the status word from before or after the update.

// File: rtl/nru_pkg.sv
package nru_pkg;

    // Geometry of the replacement state
    localparam int NRU_WAYS = 8;
    localparam int NRU_SETS = 16;
    localparam int WAY_W    = (NRU_WAYS > 1) ? $clog2(NRU_WAYS) : 1;
    localparam int SET_W    = (NRU_SETS > 1) ? $clog2(NRU_SETS) : 1;

    typedef logic [NRU_WAYS-1:0] word_t;
    typedef logic [WAY_W-1:0]    way_t;
    typedef logic [SET_W-1:0]    set_t;

    // One access (hit or fill) to a way of a set
    typedef struct packed {
        logic vld;
        set_t set;
        way_t way;
    } touch_t;

    // Status word after an access to way k
    function automatic word_t apply_touch(word_t cur, way_t k);
        word_t sel;
        word_t cleared;
        sel     = word_t'(1) << k;
        cleared = cur & ~sel;
        if (cleared == '0) begin
            return ~sel;
        end
        return cleared;
    endfunction

    // Mask of all ways below way k
    function automatic word_t below_mask(way_t k);
        return (word_t'(1) << k) - word_t'(1);
    endfunction

endpackage

// File: rtl/nru_state_array.sv
module nru_state_array
    import nru_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  touch_t touch,
    input  set_t   rd_set,
    output word_t  rd_word
);

    word_t bits_q [NRU_SETS];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < NRU_SETS; s++) begin
                bits_q[s] <= '1;
            end
        end else if (touch.vld) begin
            bits_q[touch.set] <= apply_touch(bits_q[touch.set], touch.way);
        end
    end

    assign rd_word = bits_q[rd_set];

    // R2
    touched_clear_chk: assert property (@(posedge clk) disable iff (rst)
        touch.vld |=> !bits_q[$past(touch.set)][$past(touch.way)]);

    // R9
    never_empty_chk: assert property (@(posedge clk) disable iff (rst)
        touch.vld |=> bits_q[$past(touch.set)] != '0);

    // R7
    for (genvar s = 0; s < NRU_SETS; s++) begin : g_iso
        other_set_stable_chk: assert property (@(posedge clk) disable iff (rst)
            !(touch.vld && touch.set == set_t'(s)) |=> bits_q[s] == $past(bits_q[s]));
    end

endmodule

// File: rtl/nru_victim_scan.sv
module nru_victim_scan
    import nru_pkg::*;
(
    input  word_t word,
    output way_t  way,
    output logic  found
);

    logic [NRU_WAYS:0]   any_below;
    logic [NRU_WAYS-1:0] pick;

    assign any_below[0] = 1'b0;

    for (genvar i = 0; i < NRU_WAYS; i++) begin : g_chain
        assign any_below[i+1] = any_below[i] | word[i];
        assign pick[i]        = word[i] & ~any_below[i];
    end

    always_comb begin
        way = '0;
        for (int j = 0; j < NRU_WAYS; j++) begin
            if (pick[j]) begin
                way = way | way_t'(j);
            end
        end
    end

    assign found = any_below[NRU_WAYS];

    // R4
    one_pick_chk: assert final ($onehot0(pick));

endmodule

// File: rtl/nru_replacer.sv
module nru_replacer
    import nru_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 touch_vld,
    input  logic [SET_W-1:0]     touch_set,
    input  logic [WAY_W-1:0]     touch_way,
    input  logic                 victim_req,
    input  logic [SET_W-1:0]     victim_set,
    output logic                 victim_vld,
    output logic [WAY_W-1:0]     victim_way
);

    touch_t touch;
    word_t  rd_word;
    way_t   scan_way;
    logic   scan_found;
    logic   vld_q;
    way_t   way_q;
    word_t  seen_word_q;

    assign touch = '{vld: touch_vld, set: touch_set, way: touch_way};

    nru_state_array u_array (
        .clk     (clk),
        .rst     (rst),
        .touch   (touch),
        .rd_set  (victim_set),
        .rd_word (rd_word)
    );

    nru_victim_scan u_scan (
        .word  (rd_word),
        .way   (scan_way),
        .found (scan_found)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_q       <= 1'b0;
            way_q       <= '0;
            seen_word_q <= '1;
        end else begin
            vld_q <= victim_req;
            if (victim_req) begin
                way_q       <= scan_way;
                seen_word_q <= rd_word;
            end
        end
    end

    assign victim_vld = vld_q;
    assign victim_way = way_q;

    // R5
    vld_follows_req_chk: assert property (@(posedge clk) disable iff (rst)
        victim_req |=> victim_vld);

    // R5
    no_spurious_vld_chk: assert property (@(posedge clk) disable iff (rst)
        !victim_req |=> !victim_vld);

    // R9
    victim_exists_chk: assert property (@(posedge clk) disable iff (rst)
        victim_req |-> scan_found);

    // R4
    victim_eligible_chk: assert property (@(posedge clk) disable iff (rst)
        victim_vld |-> seen_word_q[victim_way]);

    // R4
    victim_lowest_chk: assert property (@(posedge clk) disable iff (rst)
        victim_vld |-> (seen_word_q & below_mask(victim_way)) == '0);

endmodule

// File: tb/tb_nru_replacer.sv
module tb_nru_replacer;
    import nru_pkg::*;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic touch_vld = 1'b0;
    logic [SET_W-1:0] touch_set = '0;
    logic [WAY_W-1:0] touch_way = '0;
    logic victim_req = 1'b0;
    logic [SET_W-1:0] victim_set = '0;
    logic victim_vld;
    logic [WAY_W-1:0] victim_way;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    logic [NRU_WAYS-1:0] model [NRU_SETS];

    always #4 clk = ~clk;

    nru_replacer dut (
        .clk(clk), .rst(rst),
        .touch_vld(touch_vld), .touch_set(touch_set), .touch_way(touch_way),
        .victim_req(victim_req), .victim_set(victim_set),
        .victim_vld(victim_vld), .victim_way(victim_way)
    );

    task automatic check(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Expected behaviour from the requirements
    function automatic int exp_victim(int s);
        for (int w = 0; w < NRU_WAYS; w++) begin
            if (model[s][w]) return w;
        end
        return -1;
    endfunction

    function automatic void model_touch(int s, int w);
        logic [NRU_WAYS-1:0] one;
        logic [NRU_WAYS-1:0] nxt;
        one = '0;
        one[w] = 1'b1;
        nxt = model[s] & ~one;
        if (nxt == '0) nxt = ~one;
        model[s] = nxt;
    endfunction

    task automatic touch(int s, int w);
        @(negedge clk);
        touch_vld = 1'b1;
        touch_set = SET_W'(s);
        touch_way = WAY_W'(w);
        @(negedge clk);
        touch_vld = 1'b0;
        model_touch(s, w);
    endtask

    task automatic lookup(string req, int s);
        @(negedge clk);
        victim_req = 1'b1;
        victim_set = SET_W'(s);
        @(negedge clk);
        victim_req = 1'b0;
        check(req, "victim_vld", int'(victim_vld), 1);
        check(req, "victim_way", int'(victim_way), exp_victim(s));
    endtask

    task automatic test_reset();
        check("R1", "victim_vld after reset", int'(victim_vld), 0);
        lookup("R1", 0);
        lookup("R1", NRU_SETS - 1);
        check("R1", "way 0 after reset", int'(victim_way), 0);
    endtask

    task automatic test_in_order();
        touch(3, 0);
        lookup("R2", 3);
        touch(3, 1);
        touch(3, 2);
        lookup("R4", 3);
        check("R4", "set3 victim", int'(victim_way), 3);
    endtask

    task automatic test_refresh();
        for (int w = 0; w < NRU_WAYS - 1; w++) touch(5, w);
        lookup("R3", 5);
        check("R3", "last eligible", int'(victim_way), NRU_WAYS - 1);
        touch(5, NRU_WAYS - 1);
        lookup("R3", 5);
        check("R3", "after refresh", int'(victim_way), 0);
        touch(5, 0);
        lookup("R3", 5);
        check("R3", "refilled skips way0", int'(victim_way), 1);
    endtask

    task automatic test_redundant();
        touch(6, 2);
        touch(6, 2);
        lookup("R8", 6);
        check("R8", "repeat touch", int'(victim_way), 0);
        touch(6, 0);
        touch(6, 0);
        lookup("R8", 6);
        check("R8", "repeat way0", int'(victim_way), 1);
    endtask

    task automatic test_isolation();
        lookup("R7", 7);
        check("R7", "untouched set", int'(victim_way), 0);
        lookup("R7", 3);
        check("R7", "set3 kept", int'(victim_way), 3);
    endtask

    task automatic test_same_cycle();
        @(negedge clk);
        touch_vld  = 1'b1;
        touch_set  = SET_W'(9);
        touch_way  = WAY_W'(0);
        victim_req = 1'b1;
        victim_set = SET_W'(9);
        @(negedge clk);
        touch_vld  = 1'b0;
        victim_req = 1'b0;
        check("R6", "pre-update victim", int'(victim_way), 0);
        check("R5", "vld one cycle after req", int'(victim_vld), 1);
        model_touch(9, 0);
        @(negedge clk);
        check("R5", "vld drops without req", int'(victim_vld), 0);
        lookup("R6", 9);
        check("R6", "post-update victim", int'(victim_way), 1);
    endtask

    task automatic test_scattered();
        touch(10, 5); touch(10, 0); touch(10, 3); touch(10, 1);
        lookup("R4", 10);
        check("R4", "scattered", int'(victim_way), 2);
        touch(10, 2); touch(10, 4); touch(10, 6);
        lookup("R4", 10);
        check("R4", "only top left", int'(victim_way), 7);
        touch(10, 7);
        lookup("R9", 10);
        check("R9", "refresh from way7", int'(victim_way), 0);
    endtask

    initial begin
        for (int s = 0; s < NRU_SETS; s++) model[s] = '1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        test_reset();
        test_in_order();
        test_refresh();
        test_redundant();
        test_isolation();
        test_same_cycle();
        test_scattered();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule